// File: doc/BRIEF.md
# Shared Clock-Enable Prescaler

This block turns the main system clock into eight slow clock-enable strobes for a family of peripherals. A single binary counter, clocked by the main clock, supplies all eight. Each strobe is high for one main-clock cycle at a fixed divide ratio. A consumer never uses a strobe as a clock. It samples the strobe inside its own main-clock process and uses it to qualify the work done there.

Any number of clients, set by a parameter, each drive one request bit. The counter advances while at least one request bit is high. When every request bit is low, the counter is cleared and all strobes are held low, which saves dynamic power. A client that withdraws its request cannot halt the counter while another client still needs it. The strobes are registered, so they carry no combinational glitches. Because all of them are decoded from the same counter, every strobe of a slow ratio lands on a cycle where all faster strobes are also high.

Top module: `cegen_prescaler`

## Requirements
- R1: While the reset input is low, and after it is released for as long as no request has been sampled high, all eight strobe outputs are low.
- R2: Output bit i is the divide-by-2^e strobe, with e = 1, 2, 3, 6, 7, 10, 11, 12 for i = 0 to 7. Bit 0 is therefore the divide-by-2 strobe and bit 7 is the divide-by-4096 strobe. Let k be the number of consecutive rising edges at which the OR of the requests was sampled high. Bit i is high in the cycle after such an edge exactly when k is a non-zero multiple of 2^e.
- R3: Any single request bit, held high by itself with the others low, keeps the counter running with the timing of R2.
- R4: If one request bit falls while another is high, the count k continues without a break and the strobe phase is unchanged.
- R5: A rising edge at which all request bits are low clears the count. All strobes are low in the following cycle.
- R6: When the requests rise from the idle state, the first divide-by-N strobe appears after the N-th rising edge with a request high. For example, the divide-by-8 strobe stays low after edges 1 to 7 and is high after edge 8.
- R7: Whenever a strobe of a slower ratio is high, every strobe of a faster ratio is high in the same cycle.
- R8: Driving the reset input low forces all strobes low at once, with no clock edge needed. After reset is released, internal operation resumes at the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Main system clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | NUM_REQ | One enable request per client; the counter runs while any bit is high |
| strobe_o | output | 8 | Registered clock-enable strobes; bit 0 is divide-by-2, bit 7 is divide-by-4096 |

## Verification
The embedded assertions check on every cycle that:
- the counter steps by exactly one when a request is high and returns to zero when none is;
- no strobe lasts longer than a single cycle;
- the strobes stay nested by ratio;
- an idle request vector silences all outputs on the next cycle.

Only the bench's scenarios can show the following:
- the full ratio pattern over a complete 4096-cycle period;
- the exact cycle of the first strobe after a restart;
- an unbroken phase when requests hand over from one client to another;
- the immediate effect of asserting reset between clock edges.

// File: rtl/cegen_pkg.sv
package cegen_pkg;

  // number of strobe taps
  localparam int NUM_TAPS = 8;

  // log2 of the divide ratio of each tap, fastest first
  function automatic int tap_exp(input int idx);
    case (idx)
      0:       return 1;
      1:       return 2;
      2:       return 3;
      3:       return 6;
      4:       return 7;
      5:       return 10;
      6:       return 11;
      default: return 12;
    endcase
  endfunction

  // the counter only needs as many bits as the slowest tap
  localparam int CNT_W = tap_exp(NUM_TAPS - 1);

  typedef logic [NUM_TAPS-1:0] strobe_vec_t;
  typedef logic [CNT_W-1:0]    count_t;

endpackage

// File: rtl/cegen_rst_sync.sv
module cegen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  // shift ones in after release; assertion is asynchronous
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/cegen_req_merge.sv
module cegen_req_merge #(
  parameter int NUM_REQ = 4
) (
  input  logic [NUM_REQ-1:0] req_i,
  output logic               run_o
);

  // any client holding its request keeps the counter alive
  always_comb begin
    run_o = 1'b0;
    for (int i = 0; i < NUM_REQ; i++) begin
      run_o = run_o | req_i[i];
    end
  end

endmodule

// File: rtl/cegen_counter.sv
module cegen_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_nxt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // next state: advance while running, clear when idle
  always_comb begin
    if (run_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_nxt_o = cnt_d;

  // R3
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

  // R5
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/cegen_tap.sv
module cegen_tap #(
  parameter int EXP = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [EXP-1:0] cnt_low_i,
  output logic           strobe_o
);

  logic strobe_q;
  logic strobe_d;

  // decode from the next count so the registered strobe lines up with it
  always_comb begin
    strobe_d = run_i && (cnt_low_i == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
    end
  end

  assign strobe_o = strobe_q;

  // R2
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |=> !strobe_q);

endmodule

// File: rtl/cegen_prescaler.sv
module cegen_prescaler #(
  parameter int NUM_REQ = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_REQ-1:0]             req_i,
  output logic [cegen_pkg::NUM_TAPS-1:0] strobe_o
);

  import cegen_pkg::*;

  logic   rst_sync_n;
  logic   run;
  count_t cnt_nxt;

  cegen_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  cegen_req_merge #(.NUM_REQ(NUM_REQ)) u_merge (
    .req_i (req_i),
    .run_o (run)
  );

  cegen_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .run_i     (run),
    .cnt_nxt_o (cnt_nxt)
  );

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int E = tap_exp(g);
    cegen_tap #(.EXP(E)) u_tap (
      .clk_i     (clk_i),
      .rst_ni    (rst_sync_n),
      .run_i     (run),
      .cnt_low_i (cnt_nxt[E-1:0]),
      .strobe_o  (strobe_o[g])
    );
  end

  // R7
  for (genvar g = 0; g < NUM_TAPS - 1; g++) begin : g_nest
    nest_order_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      strobe_o[g+1] |-> strobe_o[g]);
  end

  // R5
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (req_i == '0) |=> (strobe_o == '0));

endmodule

// File: tb/cegen_prescaler_test.sv
module cegen_prescaler_test;

  localparam int NREQ = 4;

  logic            clk   = 1'b0;
  logic            rst_n = 1'b0;
  logic [NREQ-1:0] req   = '0;
  logic [7:0]      strobe;

  int checks   = 0;
  int failures = 0;
  int k        = 0;
  int exps [8] = '{1, 2, 3, 6, 7, 10, 11, 12};

  cegen_prescaler #(.NUM_REQ(NREQ)) uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .req_i    (req),
    .strobe_o (strobe)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] expect_vec(input int kk);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      v[i] = (kk != 0) && ((kk % (1 << exps[i])) == 0);
    end
    return v;
  endfunction

  task automatic check_vec(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b (k=%0d)", tag, act, exp, k);
    end
  endtask

  // one cycle: drive at the falling edge, check just after the rising edge
  task automatic step(input logic [NREQ-1:0] r, input string tag);
    logic nest_ok;
    @(negedge clk);
    req = r;
    @(posedge clk);
    #1;
    k = (|r) ? k + 1 : 0;
    check_vec(tag, strobe, expect_vec(k));
    nest_ok = 1'b1;
    for (int i = 0; i < 7; i++) begin
      if (strobe[i+1] && !strobe[i]) nest_ok = 1'b0;
    end
    checks++;
    if (!nest_ok) begin
      failures++;
      $display("FAIL R7 nesting actual=%b expected=nested", strobe);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [NREQ-1:0] r;

    // R1: held in reset with a request high
    req = '1;
    repeat (5) @(posedge clk);
    #1;
    check_vec("R1 in reset", strobe, 8'h00);
    @(negedge clk);
    req   = '0;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step('0, "R1 after release");

    // R3: each requester alone
    for (int c = 0; c < NREQ; c++) begin
      for (int i = 0; i < 300; i++) step(NREQ'(1 << c), "R3 single requester");
      step('0, "R5 idle between requesters");
    end

    // R2: full periods of the slowest ratio
    for (int i = 0; i < 8200; i++) step(4'b0001, "R2 long run");

    // R4: hand the request over without a gap
    for (int i = 0; i < 50; i++) step(4'b0101, "R4 overlap");
    for (int i = 0; i < 4200; i++) step(4'b0100, "R4 after drop");

    // R5: idle clears, R6: restart timing
    step('0, "R5 idle");
    check_vec("R5 idle outputs low", strobe, 8'h00);
    for (int i = 1; i <= 8; i++) begin
      step(4'b1000, "R6 restart");
      check_vec("R6 div8 first pulse", {7'b0, strobe[2]}, {7'b0, (i == 8)});
    end
    step('0, "R5 idle again");

    // mixed pattern with occasional idle cycles
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr[3:0];
      if (lfsr[9:7] == 3'b000) r = '0;
      step(r, "R2 mixed pattern");
    end

    // R8: reset asserted between edges while div2 is high
    step('0, "R8 prep");
    step(4'b0010, "R8 prep");
    step(4'b0010, "R8 prep");
    check_vec("R8 div2 high before reset", {7'b0, strobe[0]}, 8'h01);
    rst_n = 1'b0;
    #1;
    check_vec("R8 async reset", strobe, 8'h00);
    k = 0;
    @(negedge clk);
    req   = '0;
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step('0, "R1 after second release");
    for (int i = 0; i < 70; i++) step(4'b0011, "R6 after reset");

    summary();
    $finish;
  end

endmodule